// File: doc/BRIEF.md
# Receive-Path Soft Gain Limiter

This block sits on the receive side of a voice path. Each 8 kHz frame it takes one signed linear PCM sample, updates a running estimate of the signal level, and scales the sample so that loud far-end speech cannot drive the loop into howling. Quiet signals pass at unity gain. Over a 8.5 dB window above the knee, the attenuation follows the excess so the output stays at the knee level. Above that window the attenuation stays at its 8.5 dB ceiling.

A control input switches the limiter on or off. The block does not follow that input directly. It latches the input once when reset is released and again on each falling edge of an interrupt strobe, and it holds the latched value between those events. Attenuation moves in 0.5 dB steps and changes by at most one step per frame. The applied step is reported next to every output sample.

Top module: `sgl_rx_limiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `lim_valid`, `lim_sample` and `atten_step` are all 0. Reset also clears the level estimate.
- R2: `lim_valid` is high exactly one cycle after each cycle in which `frame_stb` is high, and is low in all other cycles.
- R3: While the latched enable is 0, each output sample equals its input sample and `atten_step` is 0 after every frame.
- R4: The latched enable takes the value of `gc_en` in the first clock cycle after reset is released, and in every cycle where `irq_n` is low after being high in the previous cycle. `gc_en` has no effect at any other time. A frame that arrives in the same cycle as a capture still uses the value held before that capture.
- R5: Each frame the magnitude m = |x| is formed, with -2^(W-1) mapped to 2^(W-1)-1. The level estimate becomes e' = e + floor((m - e) / 2^AVG_SHIFT).
- R6: The target step is the number of indices k in 1..STEPS-1 for which e' >= T_k. Here T_0 = THR_BASE and T_k = floor((T_(k-1)*34711 + 16384) / 32768), which is a 0.5 dB rise per index. Below T_1 the target is 0. At or above T_(STEPS-1) the target is STEPS-1 (8.5 dB).
- R7: While enabled, each frame moves the applied step one place toward the target, or leaves it unchanged if it already equals the target.
- R8: The gain for step s is G_s, with G_0 = 32768 and G_s = floor((G_(s-1)*30935 + 16384) / 32768) (Q1.15, -0.5 dB per step). The output is floor((x*G_s + 16384) / 32768), saturated to W bits. At step 0 the output equals the input.
- R9: `atten_step` changes only in a cycle where `lim_valid` is high, and it holds its value between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | Marks a cycle that carries a new receive sample |
| rx_sample | input | W | Signed linear receive sample |
| gc_en | input | 1 | Gain-control on/off level, captured per R4 |
| irq_n | input | 1 | Active-low interrupt strobe; its falling edge captures `gc_en` |
| lim_sample | output | W | Attenuated sample |
| lim_valid | output | 1 | `lim_sample` is valid this cycle |
| atten_step | output | $clog2(STEPS) | Applied attenuation in 0.5 dB steps |

## Verification
A frame and an enable capture can occur in the same cycle. This is the one place where two functions of the block compete for the same edge. The bench provokes it by driving `frame_stb` high and `irq_n` low on the same cycle while `gc_en` carries the opposite of the held value. The sample in that frame must be scaled according to the old enable, and only the next frame may show the new one. The bench also opens a window between loud frames where `gc_en` changes without an interrupt edge, and judges from the gain of the following samples that the change had no effect.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

    typedef enum logic [1:0] {
        SLEW_HOLD = 2'd0,
        SLEW_UP   = 2'd1,
        SLEW_DOWN = 2'd2
    } slew_e;

    // Level threshold for index k: base raised by k half-dB steps (x1.05929 each).
    function automatic longint thr_at(longint base, int k);
        longint t;
        t = base;
        for (int i = 0; i < k; i++) begin
            t = (t * 34711 + 16384) >>> 15;
        end
        return t;
    endfunction

    // Q1.15 gain for step k: unity lowered by k half-dB steps (x0.944061 each).
    function automatic longint gain_at(int k);
        longint g;
        g = 32768;
        for (int i = 0; i < k; i++) begin
            g = (g * 30935 + 16384) >>> 15;
        end
        return g;
    endfunction

endpackage

// File: rtl/sgl_level_est.sv
module sgl_level_est #(
    parameter int W         = 16,
    parameter int STEPS     = 18,
    parameter int AVG_SHIFT = 3,
    parameter int THR_BASE  = 1455,
    parameter int SW        = $clog2(STEPS)
) (
    input  logic [W-1:0]        env_q,
    input  logic signed [W-1:0] sample,
    output logic [W-1:0]        env_d,
    output logic [SW-1:0]       target
);
    localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0]        SMAX = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0]        mag;
    logic signed [W:0]   diff;
    logic signed [W:0]   step_amt;
    logic                above [STEPS];

    always_comb begin
        if (sample == SMIN) begin
            mag = SMAX;
        end else if (sample[W-1]) begin
            mag = W'(-sample);
        end else begin
            mag = W'(sample);
        end
        diff     = $signed({1'b0, mag}) - $signed({1'b0, env_q});
        step_amt = diff >>> AVG_SHIFT;
        env_d    = W'($signed({1'b0, env_q}) + step_amt);
    end

    assign above[0] = 1'b0;
    for (genvar k = 1; k < STEPS; k++) begin : g_thr
        localparam longint THR_K = sgl_pkg::thr_at(longint'(THR_BASE), k);
        assign above[k] = (longint'(env_d) >= THR_K);
    end

    always_comb begin
        target = '0;
        for (int k = 1; k < STEPS; k++) begin
            if (above[k]) target = target + SW'(1);
        end
    end

endmodule

// File: rtl/sgl_gain_rom.sv
module sgl_gain_rom #(
    parameter int STEPS = 18,
    parameter int GW    = 16,
    parameter int SW    = $clog2(STEPS)
) (
    input  logic [SW-1:0] step,
    output logic [GW-1:0] gain
);
    logic [GW-1:0] tab [STEPS];

    for (genvar k = 0; k < STEPS; k++) begin : g_tab
        assign tab[k] = GW'(sgl_pkg::gain_at(k));
    end

    always_comb begin
        gain = tab[0];
        for (int k = 0; k < STEPS; k++) begin
            if (int'(step) == k) gain = tab[k];
        end
    end

endmodule

// File: rtl/sgl_scaler.sv
module sgl_scaler #(
    parameter int W  = 16,
    parameter int GW = 16
) (
    input  logic signed [W-1:0] x,
    input  logic [GW-1:0]       gain,
    output logic signed [W-1:0] y
);
    localparam int PW = W + GW + 1;
    localparam logic signed [PW-1:0] RND  = PW'(1) <<< (GW - 2);
    localparam logic signed [PW-1:0] PMAX = PW'((1 << (W - 1)) - 1);
    localparam logic signed [PW-1:0] PMIN = -(PW'(1) <<< (W - 1));

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;

    always_comb begin
        prod    = PW'(x) * $signed({1'b0, gain});
        shifted = (prod + RND) >>> (GW - 1);
        if (shifted > PMAX) begin
            y = PMAX[W-1:0];
        end else if (shifted < PMIN) begin
            y = PMIN[W-1:0];
        end else begin
            y = shifted[W-1:0];
        end
    end

endmodule

// File: rtl/sgl_rx_limiter.sv
module sgl_rx_limiter #(
    parameter int W         = 16,
    parameter int STEPS     = 18,
    parameter int AVG_SHIFT = 3,
    parameter int THR_BASE  = 1455,
    parameter int GW        = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_stb,
    input  logic signed [W-1:0]  rx_sample,
    input  logic                 gc_en,
    input  logic                 irq_n,
    output logic signed [W-1:0]  lim_sample,
    output logic                 lim_valid,
    output logic [$clog2(STEPS)-1:0] atten_step
);
    import sgl_pkg::*;

    localparam int SW = $clog2(STEPS);

    typedef struct packed {
        logic [W-1:0]        env;
        logic [SW-1:0]       step;
        logic                en;
        logic                init;
        logic                irq_prev;
        logic signed [W-1:0] samp;
        logic                vld;
    } state_t;

    state_t s_d, s_q;

    logic [W-1:0]        env_nx;
    logic [SW-1:0]       target;
    logic [SW-1:0]       step_nx;
    logic [GW-1:0]       gain;
    logic signed [W-1:0] scaled;
    slew_e               dir;

    sgl_level_est #(
        .W(W), .STEPS(STEPS), .AVG_SHIFT(AVG_SHIFT), .THR_BASE(THR_BASE), .SW(SW)
    ) u_level (
        .env_q (s_q.env),
        .sample(rx_sample),
        .env_d (env_nx),
        .target(target)
    );

    always_comb begin
        if (target > s_q.step) begin
            dir = SLEW_UP;
        end else if (target < s_q.step) begin
            dir = SLEW_DOWN;
        end else begin
            dir = SLEW_HOLD;
        end
        if (!s_q.en) begin
            step_nx = '0;
        end else begin
            case (dir)
                SLEW_UP:   step_nx = s_q.step + SW'(1);
                SLEW_DOWN: step_nx = s_q.step - SW'(1);
                default:   step_nx = s_q.step;
            endcase
        end
    end

    sgl_gain_rom #(.STEPS(STEPS), .GW(GW), .SW(SW)) u_rom (
        .step(step_nx),
        .gain(gain)
    );

    sgl_scaler #(.W(W), .GW(GW)) u_scale (
        .x   (rx_sample),
        .gain(gain),
        .y   (scaled)
    );

    always_comb begin
        s_d          = s_q;
        s_d.vld      = frame_stb;
        s_d.init     = 1'b0;
        s_d.irq_prev = irq_n;
        if (s_q.init || (s_q.irq_prev && !irq_n)) begin
            s_d.en = gc_en;
        end
        if (frame_stb) begin
            s_d.env  = env_nx;
            s_d.step = step_nx;
            s_d.samp = s_q.en ? scaled : rx_sample;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.init     <= 1'b1;
            s_q.irq_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign lim_sample = s_q.samp;
    assign lim_valid  = s_q.vld;
    assign atten_step = s_q.step;

endmodule

// File: rtl/sgl_rx_limiter_chk.sv
module sgl_rx_limiter_chk #(
    parameter int W  = 16,
    parameter int SW = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_stb,
    input logic signed [W-1:0]  rx_sample,
    input logic signed [W-1:0]  lim_sample,
    input logic                 lim_valid,
    input logic [SW-1:0]        atten_step
);
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lim_valid == $past(frame_stb));

    assert_one_step_slew_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lim_valid |-> ((int'(atten_step) <= int'($past(atten_step)) + 1) &&
                       (atten_step == '0 || int'(atten_step) + 1 >= int'($past(atten_step)))));

    assert_step_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lim_valid |-> $stable(atten_step));

    assert_unity_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_valid && atten_step == '0) |-> (lim_sample == $past(rx_sample)));

endmodule

bind sgl_rx_limiter sgl_rx_limiter_chk #(.W(W), .SW(SW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .rx_sample (rx_sample),
    .lim_sample(lim_sample),
    .lim_valid (lim_valid),
    .atten_step(atten_step)
);

// File: tb/sgl_rx_limiter_tb_top.sv
`timescale 1ns/1ps
module sgl_rx_limiter_tb_top;
    localparam int W = 16, STEPS = 18, AVG_SHIFT = 3, THR_BASE = 1455, GW = 16;
    localparam int SW = $clog2(STEPS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_stb = 1'b0;
    logic signed [W-1:0] rx_sample = '0;
    logic gc_en = 1'b1;
    logic irq_n = 1'b1;
    logic signed [W-1:0] lim_sample;
    logic lim_valid;
    logic [SW-1:0] atten_step;

    always #5 clk = ~clk;

    sgl_rx_limiter #(.W(W), .STEPS(STEPS), .AVG_SHIFT(AVG_SHIFT),
                     .THR_BASE(THR_BASE), .GW(GW)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_sample(rx_sample),
        .gc_en(gc_en), .irq_n(irq_n), .lim_sample(lim_sample),
        .lim_valid(lim_valid), .atten_step(atten_step)
    );

    int tests = 0, fails = 0;
    bit done = 0;
    longint thr_m [STEPS];
    longint gain_m [STEPS];
    int env_m = 0, step_m = 0;
    bit en_m = 0;
    int q_smp[$], q_step[$];
    string q_tag[$];

    task automatic check(string tag, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // model of R5..R8 applied to one sample
    task automatic model_frame(int x, bit en, output int y);
        int mag, diff, tgt;
        longint p;
        mag  = (x == -32768) ? 32767 : (x < 0 ? -x : x);
        diff = mag - env_m;
        env_m = env_m + (diff >>> AVG_SHIFT);
        tgt = 0;
        for (int k = 1; k < STEPS; k++) if (longint'(env_m) >= thr_m[k]) tgt++;
        if (!en) step_m = 0;
        else if (tgt > step_m) step_m++;
        else if (tgt < step_m) step_m--;
        p = longint'(x) * gain_m[step_m] + 16384;
        p = p >>> 15;
        if (p > 32767) p = 32767;
        if (p < -32768) p = -32768;
        y = en ? int'(p) : x;
    endtask

    task automatic send(int x, string tag, bit with_irq = 0, bit irq_val = 0);
        int y;
        @(negedge clk);
        frame_stb = 1'b1;
        rx_sample = W'(x);
        if (with_irq) begin
            irq_n = 1'b0;
            gc_en = irq_val;
        end
        model_frame(x, en_m, y);
        if (with_irq) en_m = irq_val;
        q_smp.push_back(y);
        q_step.push_back(step_m);
        q_tag.push_back(tag);
        @(negedge clk);
        frame_stb = 1'b0;
        irq_n = 1'b1;
        check("R2 valid after frame", lim_valid, 1);
        @(negedge clk);
        check("R2 valid single cycle", lim_valid, 0);
        check("R9 step held between frames", atten_step, step_m);
    endtask

    task automatic pulse_irq(bit v);
        @(negedge clk);
        irq_n = 1'b0;
        gc_en = v;
        @(negedge clk);
        irq_n = 1'b1;
        en_m = v;
    endtask

    // monitor: pop the scoreboard as results appear
    always @(negedge clk) begin
        if (rst_n && lim_valid) begin
            if (q_smp.size() == 0) begin
                check("R2 unexpected valid", 1, 0);
            end else begin
                int es, et;
                string tg;
                es = q_smp.pop_front();
                et = q_step.pop_front();
                tg = q_tag.pop_front();
                check({tg, " sample"}, longint'(lim_sample), es);
                check({tg, " step"}, longint'(atten_step), et);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < STEPS; k++) begin
            longint t, g;
            t = THR_BASE;
            g = 32768;
            for (int i = 0; i < k; i++) begin
                t = (t * 34711 + 16384) >>> 15;
                g = (g * 30935 + 16384) >>> 15;
            end
            thr_m[k] = t;
            gain_m[k] = g;
        end
        repeat (3) @(negedge clk);
        check("R1 valid in reset", lim_valid, 0);
        check("R1 sample in reset", lim_sample, 0);
        check("R1 step in reset", atten_step, 0);
        rst_n = 1'b1;
        en_m = gc_en;
        @(negedge clk);
        check("R1 valid after reset", lim_valid, 0);
        check("R1 step after reset", atten_step, 0);

        for (int i = 0; i < 10; i++) send((i % 2) ? 500 : -500, "R6 quiet unity");
        for (int i = 0; i < 40; i++) send(20000, "R7 loud ramp up");
        check("R6 ceiling reached", atten_step, STEPS - 1);
        for (int i = 0; i < 40; i++) send(100, "R7 quiet ramp down");
        // gc_en toggled without an irq edge: must be ignored
        gc_en = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 10; i++) send(20000, "R4 held without edge");
        check("R4 still limiting", atten_step != 0, 1);
        // capture coincident with a frame: that frame keeps old enable
        send(20000, "R4 coincident capture", 1, 0);
        for (int i = 0; i < 8; i++) send(20000 - i * 3000, "R3 bypass");
        for (int i = 0; i < 20; i++) send(-32768, "R5 min magnitude bypass");
        pulse_irq(1);
        for (int i = 0; i < 30; i++) send(-32768, "R8 negative scaled");
        for (int i = 0; i < 40; i++) send(30, "R7 decay");
        for (int i = 0; i < 40; i++) send(2400, "R6 mid level");
        check("R6 mid target", (atten_step > 0) && (atten_step < STEPS - 1), 1);
        repeat (3) @(negedge clk);
        check("R2 queue drained", q_smp.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule